// File: doc/BRIEF.md
# Motion-Search Instruction Core

This block is a small in-order core for block-matching motion search. Each cycle it takes one 16-bit instruction word from an external program memory, addressed by its program counter. It decodes the word with fixed logic and executes one of eight operations against a file of thirty-two 16-bit registers. The operations are jumps, moves, byte-wide constant loads, add, subtract, halving, block-difference accumulation and local-memory loads. Two flags record the sign and zero state of the last arithmetic or difference result, and conditional jumps test them.

Two operations are handed to neighbouring units: the block-difference accumulate and the local-memory load. For each one the core sends a one-cycle start pulse together with its operands and then holds its program counter until the unit returns done. No later instruction can therefore see a stale destination. The top eight registers are driven out of the block as a flat bus. They carry configuration and results to the surrounding encoder.

Top module: `mecore_top`

## Requirements
- R1: While rst_n is low and after its release, the program counter is 0, every register reads 0, both flags are clear and neither start pulse is asserted.
- R2: The opcode is instruction bits 15:13: 0 jump, 1 move, 2 constant load, 3 add, 4 subtract, 5 halve, 6 difference accumulate, 7 local load.
- R3: A constant load writes literal bits 7:0 into the upper byte of register bits 12:9 when bit 8 is 1, and into the lower byte when bit 8 is 0. The other byte is kept.
- R4: A move copies register bits 4:0 into register bits 12:8. Moves, constant loads, jumps and local loads leave both flags unchanged.
- R5: Add and subtract write rd = ra + rb or rd = ra - rb, modulo 2^16. Here rd is bits 11:8, ra is bits 7:4 and rb is bits 3:0, each a register 0 to 15.
- R6: Halve writes the source register (bits 4:0) shifted right by one with the sign bit kept into the destination (bits 12:8).
- R7: Flags take N = result bit 15 and Z = (result == 0). Jump bits 12:11 select always (0), N set (1), positive, meaning N and Z both clear (2), or Z set (3). A taken jump loads the PC with bits 10:0; otherwise the PC advances by one.
- R8: Every instruction other than difference accumulate and local load finishes in one cycle, so straight-line code advances the PC once per clock.
- R9: Difference accumulate raises sad_start for one cycle, one cycle after issue. It presents sad_acc = R[rd], sad_a = R[ra] and sad_b = R[rb], with the same field positions as R5. It holds the PC until sad_done, then writes sad_result to rd, sets the flags from it and advances.
- R10: Local load raises ld_start for one cycle with ld_addr = register bits 4:0 and ld_sel = bit 12. It holds the PC until ld_done and writes no register.
- R11: The operand outputs of both external units change only in a cycle where their start pulse is high.
- R12: spr_out slice k (bits 16k+15:16k) always shows register 24+k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 11 | Program counter, address of current instruction |
| imem_rdata | input | 16 | Instruction word at imem_addr, same cycle |
| sad_start | output | 1 | One-cycle request to the difference unit |
| sad_acc | output | 16 | Accumulator value sent with the request |
| sad_a | output | 16 | First operand sent with the request |
| sad_b | output | 16 | Second operand sent with the request |
| sad_done | input | 1 | Difference unit finished, result valid |
| sad_result | input | 16 | Accumulated difference returned |
| ld_start | output | 1 | One-cycle request to the load unit |
| ld_addr | output | 16 | Address argument for the load unit |
| ld_sel | output | 1 | Target memory select for the load unit |
| ld_done | input | 1 | Load unit finished |
| spr_out | output | 128 | Registers 24 to 31, flattened |

## Verification
A one-cycle instruction fetched after an edge takes effect on the next rising edge, so a move into registers 24 to 31 shows on spr_out one edge later. The bench therefore counts PC steps at falling edges and reads results only after a program has reached its final self-jump. A unit request appears on sad_start or ld_start one edge after issue. The write-back and PC step happen on the edge that samples done high. The bench's model units raise done a fixed number of edges after seeing start, and the bench counts exactly how many falling edges the PC stays on the issuing address.

// File: rtl/mecore_pkg.sv
package mecore_pkg;
    localparam int DATA_W = 16;
    localparam int INSN_W = 16;
    localparam int PC_W   = 11;
    localparam int NREG   = 32;
    localparam int NSPR   = 8;
    localparam int RADR_W = $clog2(NREG);

    typedef enum logic [2:0] {
        OP_JMP  = 3'd0,
        OP_MOV  = 3'd1,
        OP_CLD  = 3'd2,
        OP_ADD  = 3'd3,
        OP_SUB  = 3'd4,
        OP_HALF = 3'd5,
        OP_DIFF = 3'd6,
        OP_LOAD = 3'd7
    } opc_e;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_WDIFF,
        ST_WLOAD
    } core_st_e;

    typedef struct packed {
        opc_e              op;
        logic [4:0]        r5_dst;
        logic [4:0]        r5_src;
        logic [3:0]        r4_dst;
        logic [3:0]        r4_a;
        logic [3:0]        r4_b;
        logic [3:0]        cl_dst;
        logic              cl_hi;
        logic [7:0]        cl_lit;
        logic [1:0]        cond;
        logic [PC_W-1:0]   target;
        logic              msel;
    } dec_s;
endpackage

// File: rtl/mecore_decode.sv
module mecore_decode
    import mecore_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output dec_s              dec
);
    always_comb begin
        dec.op     = opc_e'(insn[15:13]);
        dec.r5_dst = insn[12:8];
        dec.r5_src = insn[4:0];
        dec.r4_dst = insn[11:8];
        dec.r4_a   = insn[7:4];
        dec.r4_b   = insn[3:0];
        dec.cl_dst = insn[12:9];
        dec.cl_hi  = insn[8];
        dec.cl_lit = insn[7:0];
        dec.cond   = insn[12:11];
        dec.target = insn[PC_W-1:0];
        dec.msel   = insn[12];
    end
endmodule

// File: rtl/mecore_alu.sv
module mecore_alu
    import mecore_pkg::*;
(
    input  opc_e              op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] res,
    output logic              neg,
    output logic              zero
);
    always_comb begin
        unique case (op)
            OP_ADD:  res = opa + opb;
            OP_SUB:  res = opa - opb;
            OP_HALF: res = {opa[DATA_W-1], opa[DATA_W-1:1]};
            default: res = opa;
        endcase
        neg  = res[DATA_W-1];
        zero = (res == '0);
    end
endmodule

// File: rtl/mecore_regfile.sv
module mecore_regfile
    import mecore_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [RADR_W-1:0]      waddr,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [RADR_W-1:0]      raddr0,
    input  logic [RADR_W-1:0]      raddr1,
    input  logic [RADR_W-1:0]      raddr2,
    output logic [DATA_W-1:0]      rdata0,
    output logic [DATA_W-1:0]      rdata1,
    output logic [DATA_W-1:0]      rdata2,
    output logic [NSPR*DATA_W-1:0] spr_flat
);
    localparam int SPR_BASE = NREG - NSPR;

    logic [DATA_W-1:0] regs_d [NREG];
    logic [DATA_W-1:0] regs_q [NREG];

    always_comb begin
        regs_d = regs_q;
        if (we) regs_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rdata0 = regs_q[raddr0];
    assign rdata1 = regs_q[raddr1];
    assign rdata2 = regs_q[raddr2];

    for (genvar k = 0; k < NSPR; k++) begin : g_spr
        assign spr_flat[k*DATA_W +: DATA_W] = regs_q[SPR_BASE + k];
    end
endmodule

// File: rtl/mecore_top.sv
module mecore_top
    import mecore_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    output logic [PC_W-1:0]        imem_addr,
    input  logic [INSN_W-1:0]      imem_rdata,
    output logic                   sad_start,
    output logic [DATA_W-1:0]      sad_acc,
    output logic [DATA_W-1:0]      sad_a,
    output logic [DATA_W-1:0]      sad_b,
    input  logic                   sad_done,
    input  logic [DATA_W-1:0]      sad_result,
    output logic                   ld_start,
    output logic [DATA_W-1:0]      ld_addr,
    output logic                   ld_sel,
    input  logic                   ld_done,
    output logic [NSPR*DATA_W-1:0] spr_out
);
    typedef struct packed {
        core_st_e          st;
        logic [PC_W-1:0]   pc;
        logic              fn;
        logic              fz;
        logic              dgo;
        logic              lgo;
        logic [DATA_W-1:0] dacc;
        logic [DATA_W-1:0] da;
        logic [DATA_W-1:0] db;
        logic [3:0]        ddst;
        logic [DATA_W-1:0] laddr;
        logic              lsel;
    } core_s;

    core_s cs_d, cs_q;
    dec_s  dec;

    logic                we;
    logic [RADR_W-1:0]   waddr, ra0, ra1, ra2;
    logic [DATA_W-1:0]   wdata, rd0, rd1, rd2;
    logic [DATA_W-1:0]   alu_res;
    logic                alu_n, alu_z, take;

    mecore_decode u_dec (.insn(imem_rdata), .dec(dec));

    mecore_alu u_alu (
        .op(dec.op), .opa(rd0), .opb(rd1),
        .res(alu_res), .neg(alu_n), .zero(alu_z)
    );

    mecore_regfile u_rf (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr0(ra0), .raddr1(ra1), .raddr2(ra2),
        .rdata0(rd0), .rdata1(rd1), .rdata2(rd2), .spr_flat(spr_out)
    );

    always_comb begin
        unique case (dec.op)
            OP_MOV, OP_HALF, OP_LOAD: ra0 = dec.r5_src;
            OP_CLD:                   ra0 = {1'b0, dec.cl_dst};
            default:                  ra0 = {1'b0, dec.r4_a};
        endcase
        ra1 = {1'b0, dec.r4_b};
        ra2 = {1'b0, dec.r4_dst};

        unique case (dec.cond)
            2'd0: take = 1'b1;
            2'd1: take = cs_q.fn;
            2'd2: take = !cs_q.fn && !cs_q.fz;
            default: take = cs_q.fz;
        endcase

        cs_d     = cs_q;
        cs_d.dgo = 1'b0;
        cs_d.lgo = 1'b0;
        we       = 1'b0;
        waddr    = '0;
        wdata    = '0;

        unique case (cs_q.st)
            ST_RUN: begin
                cs_d.pc = cs_q.pc + 1'b1;
                unique case (dec.op)
                    OP_JMP: if (take) cs_d.pc = dec.target;
                    OP_MOV: begin
                        we    = 1'b1;
                        waddr = dec.r5_dst;
                        wdata = rd0;
                    end
                    OP_CLD: begin
                        we    = 1'b1;
                        waddr = {1'b0, dec.cl_dst};
                        wdata = dec.cl_hi ? {dec.cl_lit, rd0[7:0]}
                                          : {rd0[15:8], dec.cl_lit};
                    end
                    OP_ADD, OP_SUB: begin
                        we      = 1'b1;
                        waddr   = {1'b0, dec.r4_dst};
                        wdata   = alu_res;
                        cs_d.fn = alu_n;
                        cs_d.fz = alu_z;
                    end
                    OP_HALF: begin
                        we      = 1'b1;
                        waddr   = dec.r5_dst;
                        wdata   = alu_res;
                        cs_d.fn = alu_n;
                        cs_d.fz = alu_z;
                    end
                    OP_DIFF: begin
                        cs_d.pc   = cs_q.pc;
                        cs_d.st   = ST_WDIFF;
                        cs_d.dgo  = 1'b1;
                        cs_d.dacc = rd2;
                        cs_d.da   = rd0;
                        cs_d.db   = rd1;
                        cs_d.ddst = dec.r4_dst;
                    end
                    default: begin
                        cs_d.pc    = cs_q.pc;
                        cs_d.st    = ST_WLOAD;
                        cs_d.lgo   = 1'b1;
                        cs_d.laddr = rd0;
                        cs_d.lsel  = dec.msel;
                    end
                endcase
            end
            ST_WDIFF: if (sad_done) begin
                we      = 1'b1;
                waddr   = {1'b0, cs_q.ddst};
                wdata   = sad_result;
                cs_d.fn = sad_result[DATA_W-1];
                cs_d.fz = (sad_result == '0);
                cs_d.pc = cs_q.pc + 1'b1;
                cs_d.st = ST_RUN;
            end
            default: if (ld_done) begin
                cs_d.pc = cs_q.pc + 1'b1;
                cs_d.st = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '{st: ST_RUN, default: '0};
        else        cs_q <= cs_d;
    end

    assign imem_addr = cs_q.pc;
    assign sad_start = cs_q.dgo;
    assign sad_acc   = cs_q.dacc;
    assign sad_a     = cs_q.da;
    assign sad_b     = cs_q.db;
    assign ld_start  = cs_q.lgo;
    assign ld_addr   = cs_q.laddr;
    assign ld_sel    = cs_q.lsel;

    assert_diff_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sad_start |=> !sad_start);
    assert_load_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ld_start |=> !ld_start);
    assert_pc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q.st == ST_WDIFF && !sad_done) |=> $stable(imem_addr));
    assert_pc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q.st == ST_WLOAD && !ld_done) |=> $stable(imem_addr));
    assert_gated_diff_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !sad_start |-> ($stable(sad_a) && $stable(sad_b) && $stable(sad_acc)));
    assert_gated_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_start |-> ($stable(ld_addr) && $stable(ld_sel)));
    assert_flags_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs_q.fn && cs_q.fz));
endmodule

// File: tb/mecore_top_bench.sv
`timescale 1ns/1ps
module mecore_top_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [10:0]  imem_addr;
    logic [15:0]  imem_rdata;
    logic         sad_start, sad_done, ld_start, ld_done, ld_sel;
    logic [15:0]  sad_acc, sad_a, sad_b, sad_result, ld_addr;
    logic [127:0] spr_out;
    logic [15:0]  imem [64];
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    mecore_top u_mecore_top (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .sad_start(sad_start), .sad_acc(sad_acc), .sad_a(sad_a), .sad_b(sad_b),
        .sad_done(sad_done), .sad_result(sad_result), .ld_start(ld_start),
        .ld_addr(ld_addr), .ld_sel(ld_sel), .ld_done(ld_done), .spr_out(spr_out)
    );

    assign imem_rdata = imem[imem_addr[5:0]];

    // model units: done one cycle, a fixed number of edges after start
    logic [2:0]  dcnt, lcnt;
    logic [15:0] dres;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dcnt <= 0; lcnt <= 0; dres <= 0;
        end else begin
            if (sad_start) begin
                dcnt <= 3;
                dres <= sad_acc + ((sad_a > sad_b) ? sad_a - sad_b : sad_b - sad_a);
            end else if (dcnt != 0) dcnt <= dcnt - 1;
            if (ld_start) lcnt <= 2;
            else if (lcnt != 0) lcnt <= lcnt - 1;
        end
    end
    assign sad_done   = (dcnt == 1);
    assign sad_result = dres;
    assign ld_done    = (lcnt == 1);

    function automatic logic [15:0] e_j(input logic [1:0] c, input int t);
        return {3'd0, c, t[10:0]};
    endfunction
    function automatic logic [15:0] e_mov(input int d, input int s);
        return {3'd1, d[4:0], 3'd0, s[4:0]};
    endfunction
    function automatic logic [15:0] e_cld(input int d, input logic hi, input logic [7:0] v);
        return {3'd2, d[3:0], hi, v};
    endfunction
    function automatic logic [15:0] e_3(input logic [2:0] op, input int d, input int a, input int b);
        return {op, 1'b0, d[3:0], a[3:0], b[3:0]};
    endfunction
    function automatic logic [15:0] e_half(input int d, input int s);
        return {3'd5, d[4:0], 3'd0, s[4:0]};
    endfunction
    function automatic logic [15:0] e_ld(input logic sel, input int s);
        return {3'd7, sel, 7'd0, s[4:0]};
    endfunction

    function automatic logic [15:0] spr(input int k);
        return spr_out[k*16 +: 16];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 64; i++) imem[i] = e_j(2'd0, i);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        clear_prog();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 pc", imem_addr, 0);
        chk("R1 spr", spr_out[31:0], 0);
        chk("R1 starts", {sad_start, ld_start}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 spr after release", {spr(7), spr(0)}, 0);
    endtask

    task automatic t_const();
        clear_prog();
        imem[0] = e_cld(1, 1'b0, 8'h34);
        imem[1] = e_cld(1, 1'b1, 8'h12);
        imem[2] = e_cld(2, 1'b1, 8'hAB);
        imem[3] = e_mov(24, 1);
        imem[4] = e_mov(25, 2);
        imem[5] = e_cld(1, 1'b0, 8'h99);
        imem[6] = e_mov(26, 1);
        do_reset();
        repeat (12) @(negedge clk);
        chk("R3 hi+lo", spr(0), 16'h1234);
        chk("R3 hi only", spr(1), 16'hAB00);
        chk("R3 lo keeps upper", spr(2), 16'h1299);
        chk("R12 unwritten spr", spr(7), 0);
    endtask

    task automatic t_arith();
        clear_prog();
        imem[0] = e_cld(1, 1'b0, 8'd5);
        imem[1] = e_cld(2, 1'b0, 8'd3);
        imem[2] = e_3(3'd3, 3, 1, 2);
        imem[3] = e_3(3'd4, 4, 2, 1);
        imem[4] = e_half(26, 4);
        imem[5] = e_half(27, 3);
        imem[6] = e_half(28, 1);
        imem[7] = e_mov(24, 3);
        imem[8] = e_mov(25, 4);
        do_reset();
        repeat (3) @(negedge clk);
        chk("R8 one step per cycle", imem_addr, 3);
        repeat (12) @(negedge clk);
        chk("R5 add", spr(0), 16'd8);
        chk("R5 sub wraps", spr(1), 16'hFFFE);
        chk("R6 halve negative", spr(2), 16'hFFFF);
        chk("R6 halve even", spr(3), 16'd4);
        chk("R6 halve odd", spr(4), 16'd2);
    endtask

    task automatic t_jump();
        clear_prog();
        imem[0]  = e_cld(1, 1'b0, 8'd1);
        imem[1]  = e_3(3'd4, 2, 1, 1);
        imem[2]  = e_j(2'd3, 4);
        imem[3]  = e_cld(5, 1'b0, 8'h11);
        imem[4]  = e_j(2'd1, 6);
        imem[5]  = e_cld(6, 1'b0, 8'h22);
        imem[6]  = e_mov(7, 1);
        imem[7]  = e_j(2'd3, 9);
        imem[8]  = e_cld(6, 1'b0, 8'h33);
        imem[9]  = e_3(3'd4, 3, 2, 1);
        imem[10] = e_j(2'd2, 12);
        imem[11] = e_cld(8, 1'b0, 8'h44);
        imem[12] = e_j(2'd1, 14);
        imem[13] = e_cld(8, 1'b0, 8'h55);
        imem[14] = e_3(3'd3, 3, 1, 1);
        imem[15] = e_j(2'd2, 17);
        imem[16] = e_cld(9, 1'b0, 8'h66);
        imem[17] = e_cld(9, 1'b1, 8'h77);
        imem[18] = e_mov(24, 5);
        imem[19] = e_mov(25, 6);
        imem[20] = e_mov(26, 8);
        imem[21] = e_mov(27, 9);
        do_reset();
        repeat (40) @(negedge clk);
        chk("R7 zero taken", spr(0), 0);
        chk("R4 move keeps flags / R7 neg not taken", spr(1), 16'h0022);
        chk("R7 pos not taken, neg taken", spr(2), 16'h0044);
        chk("R7 pos taken", spr(3), 16'h7700);
        chk("R2 halt loop pc", imem_addr, 22);
    endtask

    task automatic t_diff();
        int held;
        clear_prog();
        imem[0] = e_cld(1, 1'b0, 8'd10);
        imem[1] = e_cld(2, 1'b0, 8'h30);
        imem[2] = e_cld(3, 1'b0, 8'h10);
        imem[3] = e_3(3'd6, 1, 2, 3);
        imem[4] = e_mov(24, 1);
        imem[5] = e_j(2'd2, 7);
        imem[6] = e_cld(4, 1'b0, 8'd1);
        imem[7] = e_mov(25, 4);
        imem[8] = e_cld(2, 1'b0, 8'h99);
        imem[9] = e_3(3'd3, 5, 2, 3);
        do_reset();
        held = 0;
        for (int i = 0; i < 20 && !sad_start; i++) @(negedge clk);
        chk("R9 start seen", sad_start, 1);
        chk("R9 operands", {sad_acc, sad_a, sad_b}, {16'd10, 16'h30, 16'h10});
        while (imem_addr == 3 && held < 20) begin
            held++;
            @(negedge clk);
        end
        chk("R9 pc held cycles", held, 4);
        repeat (12) @(negedge clk);
        chk("R9 result written", spr(0), 16'h002A);
        chk("R9 flags from result", spr(1), 0);
        chk("R11 operands gated", {sad_a, sad_acc}, {16'h30, 16'd10});
    endtask

    task automatic t_load();
        int held;
        clear_prog();
        imem[0] = e_cld(1, 1'b0, 8'h55);
        imem[1] = e_ld(1'b1, 1);
        imem[2] = e_mov(24, 1);
        imem[3] = e_cld(1, 1'b0, 8'h66);
        do_reset();
        held = 0;
        for (int i = 0; i < 20 && !ld_start; i++) @(negedge clk);
        chk("R10 start and args", {ld_start, ld_sel, ld_addr}, {1'b1, 1'b1, 16'h0055});
        while (imem_addr == 1 && held < 20) begin
            held++;
            @(negedge clk);
        end
        chk("R10 pc held cycles", held, 3);
        repeat (8) @(negedge clk);
        chk("R10 no register write", spr(0), 16'h0055);
        chk("R11 load args gated", ld_addr, 16'h0055);
    endtask

    initial begin
        #(200000 * 4);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_const();
        t_arith();
        t_jump();
        t_diff();
        t_load();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule